// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Monitor

This block checks that a clock runs at the expected rate by counting its cycles between successive valid edges of a slower, independent reference signal. Typical references are a low-frequency crystal sub-clock or a mains zero-cross pulse. The reference is synchronized into the monitored clock domain, and its rising edges, falling edges or both are selected as window boundaries. Each window boundary ends one measurement and starts the next.

When a window ends, the count is captured and compared against a programmable upper limit and a programmable lower limit. Three sticky flags record that a measurement completed, that the count fell outside the limits, and that the counter wrapped during a window. Each flag drives an interrupt output through its own enable bit. Software programs the block through a small write-only register port and clears flags by writing ones.

Top module: `fmon_top`

## Requirements
- R1: After reset, all three flags, all three interrupt outputs and the captured count are zero.
- R2: The reference passes through a two-stage synchronizer. The edge-mode field (control bits 2:1) selects the valid edge: 00 selects rising, 01 selects falling, and 10 or 11 selects both.
- R3: The captured count equals the number of monitored-clock cycles between two consecutive valid reference edges. The counter restarts at each valid edge.
- R4: The first valid edge after the run bit (control bit 0) is set only starts counting. It performs no compare, sets no flag and leaves the captured count unchanged.
- R5: At each compare, the frequency-error flag (flag bit 1) is set when the count is greater than the upper limit (address 1) or less than the lower limit (address 2). A count equal to either limit is in range.
- R6: Every compare sets the measurement-end flag (flag bit 0) and loads the captured count.
- R7: When the counter is at its all-ones value inside an armed window, it wraps to zero and sets the overflow flag (flag bit 2). The captured count at the window's end is the cycle count modulo 2^CNT_W.
- R8: Flags stay set until cleared by writing a one to the matching bit at address 3 (bit 0 measurement end, bit 1 frequency error, bit 2 overflow). If a flag is set in the same cycle that it is cleared, it ends up set.
- R9: Each interrupt output is high exactly when its flag is set and its enable bit in the control register is set (bit 3 measurement end, bit 4 frequency error, bit 5 overflow).
- R10: While the run bit is clear, reference edges set no flags and leave the captured count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Monitored clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference signal |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 upper limit, 2 lower limit, 3 flag clear |
| cfg_wdata | input | DATA_W | Write data |
| irq_meas | output | 1 | Measurement-end interrupt |
| irq_ferr | output | 1 | Frequency-error interrupt |
| irq_ovf | output | 1 | Counter-overflow interrupt |
| flag_o | output | 3 | Raw flags: bit 0 measurement end, bit 1 frequency error, bit 2 overflow |
| cap_count | output | CNT_W | Count captured at the last compare |

## Verification
The bench sweeps the reference period across the whole span around both limits, so the counts one below, equal to and one above each limit are all judged. An off-by-one window count or a strict-versus-inclusive comparison mistake shows up as a shifted error flag or a wrong captured value. Separate runs cover falling-edge and both-edge selection, a window long enough to wrap a reduced-width counter, a flag clear that lands on the compare cycle, a clear of one flag that must leave the others set, and stimulus with the run bit clear. A design that compared on the arming edge, let a clear beat a new event, or kept counting while stopped would give a wrong flag or captured count in one of these runs.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'b00,
        EDGE_FALL  = 2'b01,
        EDGE_BOTH  = 2'b10,
        EDGE_BOTHX = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_UPPER = 2'd1,
        A_LOWER = 2'd2,
        A_CLEAR = 2'd3
    } reg_addr_e;

    // bit 0 measurement end, bit 1 frequency error, bit 2 overflow
    typedef struct packed {
        logic ovf;
        logic ferr;
        logic meas;
    } flags_t;

    // bit 0 run, bits 2:1 edge mode, bits 5:3 interrupt enables
    typedef struct packed {
        flags_t     ie;
        edge_mode_e mode;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int FLAG_W = $bits(flags_t);

    function automatic logic edge_pick(edge_mode_e m, logic rise, logic fall);
        case (m)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            default:   return rise | fall;
        endcase
    endfunction

endpackage

// File: rtl/fmon_regs.sv
module fmon_regs
    import fmon_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  upper_o,
    output logic [CNT_W-1:0]  lower_o,
    output flags_t            clr_o
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] upper_q;
    logic [CNT_W-1:0] lower_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            upper_q <= '1;
            lower_q <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                A_CTRL:  ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
                A_UPPER: upper_q <= wdata[CNT_W-1:0];
                A_LOWER: lower_q <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_o = '0;
        if (we && reg_addr_e'(addr) == A_CLEAR) begin
            clr_o = flags_t'(wdata[FLAG_W-1:0]);
        end
    end

    assign ctrl_o  = ctrl_q;
    assign upper_o = upper_q;
    assign lower_o = lower_q;

endmodule

// File: rtl/fmon_refsync.sv
module fmon_refsync
    import fmon_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_i,
    input  edge_mode_e mode,
    output logic       hit_o
);

    localparam int SH_W = SYNC_N + 1;

    logic [SH_W-1:0] sh_q;
    logic            rise;
    logic            fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SH_W-2:0], ref_i};
        end
    end

    assign rise  =  sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
    assign fall  = ~sh_q[SYNC_N-1] &  sh_q[SYNC_N];
    assign hit_o = edge_pick(mode, rise, fall);

endmodule

// File: rtl/fmon_window_cnt.sv
module fmon_window_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt_o,
    output logic             armed_o,
    output logic             cmp_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (hit) begin
            cnt_q   <= CNT_ONE;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            cnt_q   <= cnt_q + CNT_ONE;
        end
    end

    assign cmp_o   = run & hit & armed_q;
    assign wrap_o  = run & armed_q & ~hit & (cnt_q == CNT_MAX);
    assign cnt_o   = cnt_q;
    assign armed_o = armed_q;

endmodule

// File: rtl/fmon_judge.sv
module fmon_judge
    import fmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] upper,
    input  logic [CNT_W-1:0] lower,
    input  flags_t           clr,
    output flags_t           flags_o,
    output logic [CNT_W-1:0] cap_o
);

    flags_t           flags_q;
    flags_t           set_v;
    logic [CNT_W-1:0] cap_q;
    logic             out_of_band;

    assign out_of_band = (cnt > upper) || (cnt < lower);

    always_comb begin
        set_v      = '0;
        set_v.meas = cmp;
        set_v.ferr = cmp & out_of_band;
        set_v.ovf  = wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            cap_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~clr) | set_v;
            if (cmp) begin
                cap_q <= cnt;
            end
        end
    end

    assign flags_o = flags_q;
    assign cap_o   = cap_q;

endmodule

// File: rtl/fmon_top.sv
module fmon_top
    import fmon_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk_mon,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              irq_meas,
    output logic              irq_ferr,
    output logic              irq_ovf,
    output logic [2:0]        flag_o,
    output logic [CNT_W-1:0]  cap_count
);

    ctrl_t            ctrl_q;
    flags_t           clr_pulse;
    flags_t           flag_q;
    logic [CNT_W-1:0] upper_lim;
    logic [CNT_W-1:0] lower_lim;
    logic [CNT_W-1:0] win_cnt;
    logic             win_armed;
    logic             edge_hit;
    logic             cmp_pulse;
    logic             wrap_pulse;

    fmon_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk_mon),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .ctrl_o  (ctrl_q),
        .upper_o (upper_lim),
        .lower_o (lower_lim),
        .clr_o   (clr_pulse)
    );

    fmon_refsync #(.SYNC_N(SYNC_N)) u_sync (
        .clk   (clk_mon),
        .rst   (rst),
        .ref_i (ref_in),
        .mode  (ctrl_q.mode),
        .hit_o (edge_hit)
    );

    fmon_window_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk_mon),
        .rst     (rst),
        .run     (ctrl_q.run),
        .hit     (edge_hit),
        .cnt_o   (win_cnt),
        .armed_o (win_armed),
        .cmp_o   (cmp_pulse),
        .wrap_o  (wrap_pulse)
    );

    fmon_judge #(.CNT_W(CNT_W)) u_judge (
        .clk     (clk_mon),
        .rst     (rst),
        .cmp     (cmp_pulse),
        .wrap    (wrap_pulse),
        .cnt     (win_cnt),
        .upper   (upper_lim),
        .lower   (lower_lim),
        .clr     (clr_pulse),
        .flags_o (flag_q),
        .cap_o   (cap_count)
    );

    assign irq_meas = flag_q.meas & ctrl_q.ie.meas;
    assign irq_ferr = flag_q.ferr & ctrl_q.ie.ferr;
    assign irq_ovf  = flag_q.ovf  & ctrl_q.ie.ovf;
    assign flag_o   = flag_q;

endmodule

// File: rtl/fmon_checker.sv
module fmon_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             hit,
    input logic             armed,
    input logic [CNT_W-1:0] cnt,
    input logic [2:0]       flags,
    input logic [2:0]       clr,
    input logic [CNT_W-1:0] cap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    p_window_restart_r3: assert property (@(posedge clk) disable iff (rst)
        run && hit |=> cnt == CNT_ONE);

    p_first_edge_arms_r4: assert property (@(posedge clk) disable iff (rst)
        run && hit && !armed |=> armed && !$rose(flags[0]));

    p_ferr_with_meas_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> flags[0]);

    p_cap_on_compare_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap) |-> flags[0]);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        run && armed && !hit && cnt == CNT_MAX |=> flags[2] && cnt == '0);

    p_meas_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        flags[0] && !clr[0] |=> flags[0]);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        flags[2] && !clr[2] |=> flags[2]);

    p_idle_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0 && !armed);

endmodule

bind fmon_top fmon_checker #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk_mon),
    .rst   (rst),
    .run   (ctrl_q.run),
    .hit   (edge_hit),
    .armed (win_armed),
    .cnt   (win_cnt),
    .flags (flag_q),
    .clr   (clr_pulse),
    .cap   (cap_count)
);

// File: tb/tb_fmon_top.sv
module tb_fmon_top;

    localparam int CNT_W  = 10;
    localparam int DATA_W = 16;
    localparam int WRAP   = 1 << CNT_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ref_in = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic              irq_meas, irq_ferr, irq_ovf;
    logic [2:0]        flag_o;
    logic [CNT_W-1:0]  cap_count;

    int   n_chk  = 0;
    int   n_fail = 0;
    int   up_b   = 0;
    int   lo_b   = 0;
    logic [2:0] ie_b = '0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    fmon_top #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
        .clk_mon   (clk),
        .rst       (rst),
        .ref_in    (ref_in),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .irq_meas  (irq_meas),
        .irq_ferr  (irq_ferr),
        .irq_ovf   (irq_ovf),
        .flag_o    (flag_o),
        .cap_count (cap_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit oor(input int c);
        return (c > up_b) || (c < lo_b);
    endfunction

    task automatic wr(input logic [1:0] a, input int d);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = DATA_W'(d);
        @(negedge clk);
        cfg_we    = 1'b0;
        if (a == 2'd1) up_b = d;
        if (a == 2'd2) lo_b = d;
        if (a == 2'd0) ie_b = 3'((d >> 3) & 7);
    endtask

    // One reference period: high for hi cycles, low for lo cycles.
    // Checks at the third cycle after the rising change (action cycle done).
    task automatic ref_cycle(input int hi, input int lo, input bit do_chk, input int exp_cap,
                             input bit em, input bit ef, input bit eo, input int clr_pt,
                             input string tag);
        ref_in = 1'b1;
        for (int i = 1; i <= hi; i++) begin
            @(negedge clk);
            if (i == 3 && do_chk) begin
                if (exp_cap >= 0) check(tag, "captured count", int'(cap_count), exp_cap);
                check(tag, "meas flag", int'(flag_o[0]), int'(em));
                check(tag, "ferr flag", int'(flag_o[1]), int'(ef));
                check(tag, "ovf flag",  int'(flag_o[2]), int'(eo));
                check("R9", "irq_meas", int'(irq_meas), int'(em & ie_b[0]));
                check("R9", "irq_ferr", int'(irq_ferr), int'(ef & ie_b[1]));
                check("R9", "irq_ovf",  int'(irq_ovf),  int'(eo & ie_b[2]));
            end
            if (i == clr_pt) begin
                cfg_we    = 1'b1;
                cfg_addr  = 2'd3;
                cfg_wdata = DATA_W'(7);
            end else begin
                cfg_we = 1'b0;
            end
        end
        ref_in = 1'b0;
        cfg_we = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int prev;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "flags", int'(flag_o), 0);
        check("R1", "captured", int'(cap_count), 0);
        check("R1", "irqs", int'({irq_meas, irq_ferr, irq_ovf}), 0);

        // Rising-edge sweep, limits 20..40
        wr(2'd1, 40);
        wr(2'd2, 20);
        wr(2'd0, 32'h39);
        ref_cycle(6, 4, 1, 0, 0, 0, 0, 4, "R4 rising arm");
        prev = 10;
        for (int p = 11; p <= 51; p++) begin
            ref_cycle(6, p - 6, 1, prev, 1, oor(prev), 0, 4, "R3 R5 R6 sweep");
            prev = p;
        end

        // R2 falling edges
        wr(2'd0, 0);
        wr(2'd0, 32'h3B);
        ref_cycle(8, 22, 0, -1, 0, 0, 0, 4, "R2");
        ref_cycle(8, 22, 1, -1, 0, 0, 0, 4, "R4 falling arm");
        ref_cycle(8, 22, 1, 30, 1, 0, 0, 4, "R2 falling");

        // R2 both edges, window equals each phase
        wr(2'd0, 0);
        wr(2'd2, 5);
        wr(2'd0, 32'h3D);
        ref_cycle(9, 25, 0, -1, 0, 0, 0, 4, "R2");
        ref_cycle(9, 25, 1, 25, 1, oor(9) | oor(25), 0, 4, "R2 both");
        ref_cycle(9, 25, 1, 25, 1, oor(9) | oor(25), 0, 4, "R2 both");

        // R7 overflow
        wr(2'd0, 0);
        wr(2'd2, 20);
        wr(2'd0, 32'h39);
        ref_cycle(6, 1094, 0, -1, 0, 0, 0, 4, "R7");
        ref_cycle(6, 1094, 1, 1100 % WRAP, 1, oor(1100 % WRAP), 1, 4, "R7 wrap");
        ref_cycle(6, 24, 1, 1100 % WRAP, 1, oor(1100 % WRAP), 1, 4, "R7 wrap held");
        ref_cycle(6, 24, 1, 30, 1, 0, 0, 4, "R7 no wrap");

        // R9 interrupt enables off
        wr(2'd0, 32'h01);
        ref_cycle(6, 54, 1, 31, 1, 0, 0, 4, "R9 gated");
        ref_cycle(6, 54, 1, 60, 1, 1, 0, 0, "R9 gated ferr");

        // R8 selective clear
        wr(2'd3, 2);
        check("R8", "flags after ferr clear", int'(flag_o), 1);
        wr(2'd3, 1);
        check("R8", "flags after meas clear", int'(flag_o), 0);

        // R8 clear colliding with a compare: set wins
        ref_cycle(6, 24, 1, 62, 1, 1, 0, 2, "R8 set wins");

        // R10 stopped
        wr(2'd0, 0);
        wr(2'd3, 7);
        ref_cycle(6, 24, 1, 62, 0, 0, 0, 0, "R10 stopped");
        ref_cycle(6, 24, 1, 62, 0, 0, 0, 0, "R10 stopped");
        check("R10", "flags stay clear", int'(flag_o), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule